// File: doc/BRIEF.md
# SPI Receive Status and Error Flags

This block holds the receive-side state of a serial peripheral: a data holding register for the last accepted byte, three sticky flags (receive full, overrun, mode fault), and three control bits (mode-fault detect enable, error interrupt enable, receive interrupt enable). The serial shifter sends it a one-cycle strobe with each finished byte, and slave-select logic sends it a mode-fault condition. A CPU bus reaches the block through three strobes: status read, data read and control write.

The CPU clears a flag in two steps. First it reads the status while the flag is 1, which arms that flag. Then it makes a data read, which clears receive full and overrun, or a control write, which clears mode fault. An event that sets a flag again cancels that flag's armed state. If a byte arrives while the holding register is still full, the new byte is dropped and the older byte is kept. One interrupt line combines all request sources.

Top module: `spi_rx_status`

## Requirements
- R1: After reset, `stat_o`, `data_o` and `irq_o` are all zero. `stat_o` bit order, from bit 0: rx_full, overrun, mode_fault, mode-fault enable, error irq enable, receive irq enable.
- R2: A `rx_done` strobe while rx_full is 0 loads `rx_byte` into `data_o` and sets rx_full (`stat_o[0]`). Both are visible one cycle later.
- R3: A `rx_done` strobe while rx_full is 1 (and no clearing data read in the same cycle) sets overrun (`stat_o[1]`) and leaves `data_o` unchanged.
- R4: rx_full is cleared by a data read that follows a status read made while rx_full was 1. A data read that was not armed in this way leaves rx_full set.
- R5: Overrun is cleared by a data read that follows a status read made while overrun was 1. During that read, `data_o` still shows the byte received before the lost one.
- R6: An overrun event after the arming status read and before the data read disarms overrun, so that data read leaves overrun set. rx_full, which stayed armed, is still cleared.
- R7: Mode fault (`stat_o[2]`) is set by `fault_in` only while the mode-fault enable (`stat_o[3]`) is 1.
- R8: Writing the mode-fault enable to 0 leaves a mode fault that is already set unchanged. Once the fault is cleared, `fault_in` no longer sets it.
- R9: Mode fault is cleared by a `ctl_wr` that follows a status read made while mode fault was 1. A `ctl_wr` that was not armed in this way leaves it set.
- R10: `irq_o = (rx_full & rie) | ((overrun | mode_fault) & errie)`, where rie is `stat_o[5]` and errie is `stat_o[4]`. The output follows the registers in the same cycle.
- R11: When a data read and a `rx_done` fall in the same cycle, the read is applied first. If the read clears rx_full, the new byte is loaded, rx_full stays 1 and overrun stays 0.
- R12: `ctl_wr` loads `ctl_wdata[0]` into the mode-fault enable, `ctl_wdata[1]` into errie and `ctl_wdata[2]` into rie. The new values show in `stat_o[5:3]` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_done | input | 1 | One-cycle strobe: a byte has finished shifting in |
| rx_byte | input | DW | Received byte, valid with `rx_done` |
| fault_in | input | 1 | Mode-fault condition from slave-select logic |
| stat_rd | input | 1 | CPU status-register read strobe |
| data_rd | input | 1 | CPU data-register read strobe |
| ctl_wr | input | 1 | CPU control-register write strobe |
| ctl_wdata | input | 3 | Control write data {rie, errie, mode-fault enable} |
| stat_o | output | 6 | Status and control bits |
| data_o | output | DW | Data holding register |
| irq_o | output | 1 | Shared interrupt request |

## Verification
Each flag, the data register and the enable bits change on the first clock edge after the strobe that causes them, so the bench applies every stimulus for exactly one cycle and samples on the falling edge that follows that rising edge. The value a data read returns is taken in the read cycle itself, before the edge, because the bench has to see the older byte before the flags clear. With the default configuration the interrupt line is combinational from the registers, so it is compared in the same sample as the status bits. The bench sweeps every pairing of the two interrupt enables with four flag states and checks the interrupt each time.

// File: rtl/spi_rxs_pkg.sv
package spi_rxs_pkg;
   localparam int STAT_W   = 6;
   localparam int CTL_W    = 3;
   localparam int B_FULL   = 0;
   localparam int B_OVR    = 1;
   localparam int B_MODF   = 2;
   localparam int B_MFEN   = 3;
   localparam int B_ERRIE  = 4;
   localparam int B_RIE    = 5;
   localparam int C_MFEN   = 0;
   localparam int C_ERRIE  = 1;
   localparam int C_RIE    = 2;

   typedef struct packed {
      logic rie;
      logic errie;
      logic mfen;
   } ctl_t;
endpackage

// File: rtl/spi_rxs_ctrl.sv
module spi_rxs_ctrl
   import spi_rxs_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_wdata,
   output ctl_t             ctl_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (ctl_wr) begin
         ctl_q.mfen  <= ctl_wdata[C_MFEN];
         ctl_q.errie <= ctl_wdata[C_ERRIE];
         ctl_q.rie   <= ctl_wdata[C_RIE];
      end
   end
endmodule

// File: rtl/spi_rxs_rxpath.sv
module spi_rxs_rxpath #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_done,
   input  logic [DW-1:0] rx_byte,
   input  logic          stat_rd,
   input  logic          data_rd,
   output logic [DW-1:0] data_q,
   output logic          full_q,
   output logic          ovr_q
);
   logic arm_full, arm_ovr;
   logic full_left, ovr_left;
   logic load, lost;

   // a data read in the same cycle is applied before an arriving byte
   always_comb begin
      full_left = full_q & ~(data_rd & arm_full);
      ovr_left  = ovr_q  & ~(data_rd & arm_ovr);
      load      = rx_done & ~full_left;
      lost      = rx_done &  full_left;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q   <= '0;
         full_q   <= 1'b0;
         ovr_q    <= 1'b0;
         arm_full <= 1'b0;
         arm_ovr  <= 1'b0;
      end else begin
         full_q <= full_left | load;
         ovr_q  <= ovr_left | lost;
         if (load) data_q <= rx_byte;

         if (load)         arm_full <= 1'b0;
         else if (stat_rd) arm_full <= full_left;
         else if (data_rd) arm_full <= 1'b0;

         if (lost)         arm_ovr <= 1'b0;
         else if (stat_rd) arm_ovr <= ovr_left;
         else if (data_rd) arm_ovr <= 1'b0;
      end
   end
endmodule

// File: rtl/spi_rxs_fault.sv
module spi_rxs_fault (
   input  logic clk,
   input  logic rst_n,
   input  logic fault_in,
   input  logic mfen,
   input  logic stat_rd,
   input  logic ctl_wr,
   output logic modf_q
);
   logic arm_m, set_ev, clr, modf_left;

   always_comb begin
      set_ev    = fault_in & mfen;
      clr       = ctl_wr & arm_m;
      modf_left = modf_q & ~clr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         modf_q <= 1'b0;
         arm_m  <= 1'b0;
      end else begin
         modf_q <= modf_left | set_ev;
         if (set_ev)       arm_m <= 1'b0;
         else if (stat_rd) arm_m <= modf_left;
         else if (ctl_wr)  arm_m <= 1'b0;
      end
   end
endmodule

// File: rtl/spi_rxs_irq.sv
module spi_rxs_irq #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic full,
   input  logic ovr,
   input  logic modf,
   input  logic rie,
   input  logic errie,
   output logic irq
);
   logic req;
   assign req = (full & rie) | ((ovr | modf) & errie);

   generate
      if (IRQ_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= req;
         end
      end else begin : g_comb
         assign irq = req;
      end
   endgenerate
endmodule

// File: rtl/spi_rx_status.sv
module spi_rx_status
   import spi_rxs_pkg::*;
#(
   parameter int DW      = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_done,
   input  logic [DW-1:0]     rx_byte,
   input  logic              fault_in,
   input  logic              stat_rd,
   input  logic              data_rd,
   input  logic              ctl_wr,
   input  logic [CTL_W-1:0]  ctl_wdata,
   output logic [STAT_W-1:0] stat_o,
   output logic [DW-1:0]     data_o,
   output logic              irq_o
);
   generate
      if (DW < 1 || DW > 32) begin : g_bad_dw
         $error("spi_rx_status: DW must be 1..32");
      end
   endgenerate

   ctl_t ctl;
   logic full, ovr, modf;

   spi_rxs_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_q(ctl)
   );

   spi_rxs_rxpath #(.DW(DW)) u_rx (
      .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_byte(rx_byte),
      .stat_rd(stat_rd), .data_rd(data_rd),
      .data_q(data_o), .full_q(full), .ovr_q(ovr)
   );

   spi_rxs_fault u_mf (
      .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .mfen(ctl.mfen),
      .stat_rd(stat_rd), .ctl_wr(ctl_wr), .modf_q(modf)
   );

   spi_rxs_irq #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk(clk), .rst_n(rst_n), .full(full), .ovr(ovr), .modf(modf),
      .rie(ctl.rie), .errie(ctl.errie), .irq(irq_o)
   );

   always_comb begin
      stat_o          = '0;
      stat_o[B_FULL]  = full;
      stat_o[B_OVR]   = ovr;
      stat_o[B_MODF]  = modf;
      stat_o[B_MFEN]  = ctl.mfen;
      stat_o[B_ERRIE] = ctl.errie;
      stat_o[B_RIE]   = ctl.rie;
   end
endmodule

// File: rtl/spi_rx_status_chk.sv
module spi_rx_status_chk #(
   parameter int DW      = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_done,
   input logic [DW-1:0] rx_byte,
   input logic          fault_in,
   input logic          data_rd,
   input logic          ctl_wr,
   input logic [5:0]    stat_o,
   input logic [DW-1:0] data_o,
   input logic          irq_o
);
   a_r2_load_byte: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done && !stat_o[0] |=> stat_o[0] && data_o == $past(rx_byte));

   a_r3_keep_on_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done && stat_o[0] && !data_rd |=> stat_o[1] && $stable(data_o));

   a_r4_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      stat_o[0] && !data_rd |=> stat_o[0]);

   a_r7_modf_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_o[2] && !stat_o[3] |=> !stat_o[2]);

   a_r8_modf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      stat_o[2] && !ctl_wr |=> stat_o[2]);

   generate
      if (!IRQ_REG) begin : g_irq_chk
         a_r10_quiet_irq: assert property (@(posedge clk) disable iff (!rst_n)
            stat_o[2:0] == 3'b000 |-> !irq_o);
         a_r10_error_irq: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_o[1] || stat_o[2]) && stat_o[4] |-> irq_o);
      end
   endgenerate
endmodule

bind spi_rx_status spi_rx_status_chk #(.DW(DW), .IRQ_REG(IRQ_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_byte(rx_byte),
   .fault_in(fault_in), .data_rd(data_rd), .ctl_wr(ctl_wr),
   .stat_o(stat_o), .data_o(data_o), .irq_o(irq_o)
);

// File: tb/spi_rx_status_test.sv
module spi_rx_status_test;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_done = 1'b0;
   logic [DW-1:0] rx_byte = '0;
   logic          fault_in = 1'b0;
   logic          stat_rd = 1'b0;
   logic          data_rd = 1'b0;
   logic          ctl_wr = 1'b0;
   logic [2:0]    ctl_wdata = '0;
   logic [5:0]    stat_o;
   logic [DW-1:0] data_o;
   logic          irq_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   spi_rx_status #(.DW(DW)) uut (
      .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_byte(rx_byte),
      .fault_in(fault_in), .stat_rd(stat_rd), .data_rd(data_rd),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .stat_o(stat_o), .data_o(data_o), .irq_o(irq_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // one bus/stimulus cycle, applied after a falling edge, sampled at the next falling edge
   task automatic op(input bit s, input bit d, input bit w, input logic [2:0] wd,
                     input bit rx, input logic [DW-1:0] b, input bit f);
      stat_rd = s; data_rd = d; ctl_wr = w; ctl_wdata = wd;
      rx_done = rx; rx_byte = b; fault_in = f;
      @(posedge clk);
      @(negedge clk);
      stat_rd = 0; data_rd = 0; ctl_wr = 0; rx_done = 0; fault_in = 0;
   endtask

   task automatic byte_in(input logic [DW-1:0] b); op(0,0,0,3'b0,1,b,0); endtask
   task automatic srd();  op(1,0,0,3'b0,0,'0,0); endtask
   task automatic drd();  op(0,1,0,3'b0,0,'0,0); endtask
   task automatic cwr(input logic [2:0] v); op(0,0,1,v,0,'0,0); endtask
   task automatic flt();  op(0,0,0,3'b0,0,'0,1); endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 stat", stat_o, 6'b0);
      chk("R1 data", data_o, 0);
      chk("R1 irq", irq_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 control write
      cwr(3'b111);
      chk("R12 enables", stat_o[5:3], 3'b111);
      cwr(3'b010);
      chk("R12 enables", stat_o[5:3], 3'b010);

      // R2 / R4 sweep of byte values
      for (int i = 0; i < 32; i++) begin
         logic [DW-1:0] b;
         b = DW'((i * 37) ^ 8'h5A);
         byte_in(b);
         chk("R2 full", stat_o[0], 1);
         chk("R2 data", data_o, b);
         srd();
         chk("R4 data during read", data_o, b);
         drd();
         chk("R4 cleared", stat_o[1:0], 2'b00);
      end

      // R4 data read without status read does not clear
      byte_in(8'hC3);
      drd();
      chk("R4 unarmed read", stat_o[0], 1);
      srd(); drd();
      chk("R4 armed read", stat_o[0], 0);

      // R3 / R5 overrun keeps older byte
      byte_in(8'h11);
      byte_in(8'h22);
      chk("R3 ovr set", stat_o[1:0], 2'b11);
      chk("R3 data kept", data_o, 8'h11);
      srd();
      chk("R5 data at read", data_o, 8'h11);
      drd();
      chk("R5 cleared", stat_o[1:0], 2'b00);

      // R6 overrun after arming disarms it
      byte_in(8'h33);
      byte_in(8'h44);
      srd();
      byte_in(8'h55);
      drd();
      chk("R6 ovr stays", stat_o[1], 1);
      chk("R6 full cleared", stat_o[0], 0);
      chk("R6 data", data_o, 8'h33);
      srd(); drd();
      chk("R6 later clear", stat_o[1], 0);

      // R11 same-cycle read and arrival
      byte_in(8'h66);
      srd();
      op(0,1,0,3'b0,1,8'h77,0);
      chk("R11 full", stat_o[0], 1);
      chk("R11 ovr", stat_o[1], 0);
      chk("R11 data", data_o, 8'h77);
      srd(); drd();

      // R7 mode fault gating
      cwr(3'b000);
      flt();
      chk("R7 gated", stat_o[2], 0);
      cwr(3'b001);
      flt();
      chk("R7 set", stat_o[2], 1);

      // R8 / R9
      cwr(3'b000);
      chk("R8 kept", stat_o[2], 1);
      chk("R9 unarmed write", stat_o[2], 1);
      srd();
      cwr(3'b000);
      chk("R9 cleared", stat_o[2], 0);
      flt();
      chk("R8 blocked", stat_o[2], 0);

      // R10 sweep: enable pairs x flag scenarios
      for (int e = 0; e < 4; e++) begin
         for (int sc = 0; sc < 4; sc++) begin
            bit rie, er, rf, ov, mf, ex;
            rie = e[0]; er = e[1];
            cwr({rie, er, 1'b1});
            if (sc == 1 || sc == 2) byte_in(8'hA0 + DW'(sc));
            if (sc == 2) byte_in(8'hEE);
            if (sc == 3) flt();
            rf = (sc == 1 || sc == 2); ov = (sc == 2); mf = (sc == 3);
            ex = (rf & rie) | ((ov | mf) & er);
            chk("R10 irq", irq_o, ex);
            chk("R10 stat", stat_o, {rie, er, 1'b1, mf, ov, rf});
            srd(); drd();
            srd(); cwr({rie, er, 1'b1});
            chk("R10 cleanup", stat_o[2:0], 3'b000);
         end
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule